// File: doc/BRIEF.md
# SCSI Controller Command and Interrupt Register Block

This block is the byte-wide register file and command decoder for a SCSI protocol controller core. A host reaches it through a 4-bit register address. Reads and writes at the same address can mean different things. The block keeps these registers:

- the transfer-count bytes,
- status,
- interrupt cause,
- sequence step,
- flags,
- a set of configuration bytes.

The block drives a level interrupt that always mirrors the top bit of the status register.

A byte written to the command address is decoded in one cycle. Simple commands apply their effects to status, interrupt and step straight away. Selection commands and the transfer command are passed to an external sequencer as a one-cycle start strobe. The strobe carries the command code, the DMA flag and the effective transfer length. When the sequencer finishes, it pulses a done input together with new status, interrupt, step and flags values. Loading these raises the interrupt.

Reading the interrupt register is destructive. It returns the cause byte and, in the same step, clears the cause, drops the terminal-count bit, sets the step register to 4 and lowers the interrupt. Bus signalling, device lookup and data movement all sit outside this block.

Top module: `scsi_cmd_regs`

## Requirements
- R1: After reset, every readable register reads 0, with three exceptions: configuration register 1 (address 8) reads 0x07, address 0xE reads the CHIP_ID parameter (default 0x04), and irq is low. Addresses 2, 9 and 0xA always read 0.
- R2: irq equals bit 7 of the status register (address 4) at all times. A raise sets that bit and a lowering clears it.
- R3: A read of address 5 returns the interrupt byte held before the read. On the next clock edge, the interrupt byte becomes 0, status bit 4 (terminal count) and bit 7 clear, and the step register (address 6) becomes 4.
- R4: A write to address 0 or 1 stores the byte in a hidden shadow and clears status bit 4. The readable count bytes at addresses 0 and 1 do not change.
- R5: A write to address 3 stores the whole byte as the command register. Bit 7 is a DMA flag and bits 6:0 are the code. When the flag is set, the readable count bytes at addresses 0 and 1 reload from their shadows.
- R6: Code 0x01 (flush) sets the interrupt byte to 0x08 and clears the step and flags registers. Status is left as it was.
- R7: Code 0x18 (pad) sets status to 0x10, the interrupt byte to 0x08 and the step register to 0.
- R8: Code 0x03 (bus reset) sets the interrupt byte to 0x80. It raises irq only when bit 6 of configuration register 1 is 0; otherwise irq is unchanged.
- R9: Code 0x12 sets the interrupt byte to 0x20, clears step and flags, and raises irq. Code 0x45 clears the interrupt byte and raises irq. Code 0x44 only clears the interrupt byte.
- R10: Code 0x02 restores every register, the shadows and the command register to their R1 values.
- R11: Codes 0x10, 0x41, 0x42 and 0x43 make seq_start high for exactly the one cycle after the write edge. In that cycle seq_code holds the code and seq_dma the flag. seq_len holds the 16-bit count {address 1, address 0} in effect after any reload, where a count of zero gives 65536.
- R12: A done pulse loads status from done_status with bit 7 forced to 1, and loads the interrupt, step and flags registers from the matching inputs. When a register access falls in the same cycle, the access's field updates take precedence.
- R13: Codes that R6 to R11 do not name change only the command register (and the count bytes through the DMA flag).
- R14: Writes to addresses 8 and 0xB to 0xF read back. Writes to addresses 2, 4, 5, 6, 7, 9 and 0xA change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for destructive reads) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt |
| seq_start | output | 1 | One-cycle start strobe to the sequencer |
| seq_code | output | 7 | Command code carried with the strobe |
| seq_dma | output | 1 | DMA flag carried with the strobe |
| seq_len | output | 17 | Effective transfer length (1 to 65536) |
| seq_done | input | 1 | Sequencer completion pulse |
| done_status | input | 8 | Status value loaded on done |
| done_intr | input | 8 | Interrupt byte loaded on done |
| done_step | input | 8 | Step value loaded on done |
| done_flags | input | 8 | Flags value loaded on done |

## Verification
Read data is combinational, so the bench samples reg_rdata within the same cycle that reg_rd is raised. Every register update, the irq level and the seq_start strobe appear one edge after the write, read or done cycle. The bench therefore samples them at the falling edge that follows that rising edge. The strobe is checked again one cycle later to confirm it has dropped. A bench-side model of every readable byte is updated after each access. The model is compared against full register sweeps and against irq after every random operation.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int CODE_W = BYTE_W - 1;
  localparam int LEN_W  = 2 * BYTE_W + 1;
  localparam int NUP    = 5;  // configuration bytes at 0xB..0xF

  typedef logic [BYTE_W-1:0] byte_t;

  localparam logic [ADDR_W-1:0] RA_CNT_LO  = 4'h0;
  localparam logic [ADDR_W-1:0] RA_CNT_MID = 4'h1;
  localparam logic [ADDR_W-1:0] RA_CMD     = 4'h3;
  localparam logic [ADDR_W-1:0] RA_STAT    = 4'h4;
  localparam logic [ADDR_W-1:0] RA_INTR    = 4'h5;
  localparam logic [ADDR_W-1:0] RA_STEP    = 4'h6;
  localparam logic [ADDR_W-1:0] RA_FLAGS   = 4'h7;
  localparam logic [ADDR_W-1:0] RA_CFG1    = 4'h8;
  localparam logic [ADDR_W-1:0] RA_UPBASE  = 4'hB;
  localparam int                ID_SLOT    = 3;  // 0xE - 0xB

  localparam int ST_IRQ_BIT     = 7;
  localparam int ST_TC_BIT      = 4;
  localparam int CFG1_QUIET_BIT = 6;

  localparam byte_t CFG1_RESET  = 8'h07;
  localparam byte_t STEP_ACK    = 8'h04;
  localparam byte_t INTR_FDONE  = 8'h08;
  localparam byte_t INTR_BUSRST = 8'h80;
  localparam byte_t INTR_DISC   = 8'h20;
  localparam byte_t STAT_PADV   = 8'h10;

  localparam logic [CODE_W-1:0] OP_FLUSH  = 7'h01;
  localparam logic [CODE_W-1:0] OP_RESET  = 7'h02;
  localparam logic [CODE_W-1:0] OP_BUSRST = 7'h03;
  localparam logic [CODE_W-1:0] OP_XFER   = 7'h10;
  localparam logic [CODE_W-1:0] OP_MSGOK  = 7'h12;
  localparam logic [CODE_W-1:0] OP_PAD    = 7'h18;
  localparam logic [CODE_W-1:0] OP_SEL    = 7'h41;
  localparam logic [CODE_W-1:0] OP_SELA   = 7'h42;
  localparam logic [CODE_W-1:0] OP_SELAS  = 7'h43;
  localparam logic [CODE_W-1:0] OP_ENSEL  = 7'h44;
  localparam logic [CODE_W-1:0] OP_DISSEL = 7'h45;

  typedef struct packed {
    logic  ld_stat;
    byte_t stat_val;
    logic  ld_intr;
    byte_t intr_val;
    logic  ld_step;
    byte_t step_val;
    logic  clr_flags;
    logic  raise;
    logic  raise_unless_quiet;
    logic  soft_rst;
    logic  start;
  } cmd_act_t;

  function automatic logic is_start_f(input logic [CODE_W-1:0] c);
    return (c == OP_XFER) || (c == OP_SEL) || (c == OP_SELA) || (c == OP_SELAS);
  endfunction

  function automatic logic is_known_f(input logic [CODE_W-1:0] c);
    return is_start_f(c) || (c == OP_FLUSH) || (c == OP_RESET) || (c == OP_BUSRST) ||
           (c == OP_MSGOK) || (c == OP_PAD) || (c == OP_ENSEL) || (c == OP_DISSEL);
  endfunction

  // zero count stands for the full 2^16 range
  function automatic logic [LEN_W-1:0] xfer_len_f(input byte_t lo, input byte_t mid);
    logic [2*BYTE_W-1:0] cnt;
    cnt = {mid, lo};
    return (cnt == '0) ? {1'b1, {(LEN_W-1){1'b0}}} : {1'b0, cnt};
  endfunction
endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_regs_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output cmd_act_t          act
);
  always_comb begin
    act = '0;
    unique case (code)
      OP_FLUSH: begin
        act.ld_intr = 1'b1; act.intr_val = INTR_FDONE;
        act.ld_step = 1'b1; act.clr_flags = 1'b1;
      end
      OP_RESET:  act.soft_rst = 1'b1;
      OP_BUSRST: begin
        act.ld_intr = 1'b1; act.intr_val = INTR_BUSRST;
        act.raise_unless_quiet = 1'b1;
      end
      OP_MSGOK: begin
        act.ld_intr = 1'b1; act.intr_val = INTR_DISC;
        act.ld_step = 1'b1; act.clr_flags = 1'b1; act.raise = 1'b1;
      end
      OP_PAD: begin
        act.ld_stat = 1'b1; act.stat_val = STAT_PADV;
        act.ld_intr = 1'b1; act.intr_val = INTR_FDONE;
        act.ld_step = 1'b1;
      end
      OP_ENSEL:  act.ld_intr = 1'b1;
      OP_DISSEL: begin act.ld_intr = 1'b1; act.raise = 1'b1; end
      default:   act.start = is_start_f(code);
    endcase
  end
endmodule

// File: rtl/scsi_start_gen.sv
module scsi_start_gen
  import scsi_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CODE_W-1:0] code,
  input  logic              dma,
  input  logic [LEN_W-1:0]  len,
  output logic              pulse,
  output logic [CODE_W-1:0] code_q,
  output logic              dma_q,
  output logic [LEN_W-1:0]  len_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      code_q <= '0;
      dma_q  <= 1'b0;
      len_q  <= '0;
    end else begin
      pulse <= fire;
      if (fire) begin
        code_q <= code;
        dma_q  <= dma;
        len_q  <= len;
      end
    end
  end
endmodule

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs
  import scsi_regs_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq,
  output logic        seq_start,
  output logic [6:0]  seq_code,
  output logic        seq_dma,
  output logic [16:0] seq_len,
  input  logic        seq_done,
  input  logic [7:0]  done_status,
  input  logic [7:0]  done_intr,
  input  logic [7:0]  done_step,
  input  logic [7:0]  done_flags
);
  byte_t cnt_lo_q, cnt_mid_q, sh_lo_q, sh_mid_q, cmd_q;
  byte_t stat_q, intr_q, step_q, flags_q, cfg1_q;
  byte_t up_q [NUP];
  byte_t n_cnt_lo, n_cnt_mid, n_sh_lo, n_sh_mid, n_cmd;
  byte_t n_stat, n_intr, n_step, n_flags, n_cfg1;
  byte_t n_up [NUP];

  // named events for the checks
  logic ev_cmd_wr, ev_intr_rd, ev_raise;
  logic [2:0] up_idx;
  cmd_act_t act;

  assign ev_cmd_wr  = reg_wr && (reg_addr == RA_CMD);
  assign ev_intr_rd = reg_rd && (reg_addr == RA_INTR);
  assign up_idx     = 3'(reg_addr - RA_UPBASE);

  scsi_cmd_decode u_dec (
    .code (reg_wdata[CODE_W-1:0]),
    .act  (act)
  );

  assign ev_raise = ev_cmd_wr && (act.raise ||
                    (act.raise_unless_quiet && !cfg1_q[CFG1_QUIET_BIT]));

  always_comb begin
    n_cnt_lo = cnt_lo_q; n_cnt_mid = cnt_mid_q;
    n_sh_lo  = sh_lo_q;  n_sh_mid  = sh_mid_q;
    n_cmd    = cmd_q;    n_stat    = stat_q;
    n_intr   = intr_q;   n_step    = step_q;
    n_flags  = flags_q;  n_cfg1    = cfg1_q;
    for (int i = 0; i < NUP; i++) n_up[i] = up_q[i];

    // lowest priority: sequencer completion
    if (seq_done) begin
      n_stat = done_status;
      n_stat[ST_IRQ_BIT] = 1'b1;
      n_intr  = done_intr;
      n_step  = done_step;
      n_flags = done_flags;
    end

    if (ev_intr_rd) begin
      n_intr = '0;
      n_stat[ST_TC_BIT]  = 1'b0;
      n_stat[ST_IRQ_BIT] = 1'b0;
      n_step = STEP_ACK;
    end

    if (reg_wr) begin
      if (reg_addr == RA_CNT_LO) begin
        n_sh_lo = reg_wdata; n_stat[ST_TC_BIT] = 1'b0;
      end else if (reg_addr == RA_CNT_MID) begin
        n_sh_mid = reg_wdata; n_stat[ST_TC_BIT] = 1'b0;
      end else if (reg_addr == RA_CMD) begin
        n_cmd = reg_wdata;
        if (reg_wdata[BYTE_W-1]) begin
          n_cnt_lo = sh_lo_q; n_cnt_mid = sh_mid_q;
        end
        if (act.ld_stat)   n_stat  = act.stat_val;
        if (act.ld_intr)   n_intr  = act.intr_val;
        if (act.ld_step)   n_step  = act.step_val;
        if (act.clr_flags) n_flags = '0;
        if (ev_raise)      n_stat[ST_IRQ_BIT] = 1'b1;
        if (act.soft_rst) begin
          n_cnt_lo = '0; n_cnt_mid = '0; n_sh_lo = '0; n_sh_mid = '0;
          n_cmd = '0; n_stat = '0; n_intr = '0; n_step = '0; n_flags = '0;
          n_cfg1 = CFG1_RESET;
          for (int i = 0; i < NUP; i++) n_up[i] = (i == ID_SLOT) ? CHIP_ID : '0;
        end
      end else if (reg_addr == RA_CFG1) begin
        n_cfg1 = reg_wdata;
      end else if (reg_addr >= RA_UPBASE) begin
        n_up[up_idx] = reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lo_q <= '0; cnt_mid_q <= '0; sh_lo_q <= '0; sh_mid_q <= '0;
      cmd_q <= '0; stat_q <= '0; intr_q <= '0; step_q <= '0; flags_q <= '0;
      cfg1_q <= CFG1_RESET;
    end else begin
      cnt_lo_q <= n_cnt_lo; cnt_mid_q <= n_cnt_mid;
      sh_lo_q  <= n_sh_lo;  sh_mid_q  <= n_sh_mid;
      cmd_q    <= n_cmd;    stat_q    <= n_stat;
      intr_q   <= n_intr;   step_q    <= n_step;
      flags_q  <= n_flags;  cfg1_q    <= n_cfg1;
    end
  end

  // one register per configuration byte; the ID slot has its own reset value
  for (genvar g = 0; g < NUP; g++) begin : g_up
    localparam byte_t RST_V = (g == ID_SLOT) ? CHIP_ID : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) up_q[g] <= RST_V;
      else        up_q[g] <= n_up[g];
    end
  end

  assign irq = stat_q[ST_IRQ_BIT];

  always_comb begin
    unique case (reg_addr)
      RA_CNT_LO:  reg_rdata = cnt_lo_q;
      RA_CNT_MID: reg_rdata = cnt_mid_q;
      RA_CMD:     reg_rdata = cmd_q;
      RA_STAT:    reg_rdata = stat_q;
      RA_INTR:    reg_rdata = intr_q;
      RA_STEP:    reg_rdata = step_q;
      RA_FLAGS:   reg_rdata = flags_q;
      RA_CFG1:    reg_rdata = cfg1_q;
      4'hB, 4'hC, 4'hD, 4'hE, 4'hF: reg_rdata = up_q[up_idx];
      default:    reg_rdata = '0;
    endcase
  end

  scsi_start_gen u_start (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (ev_cmd_wr && act.start),
    .code   (reg_wdata[CODE_W-1:0]),
    .dma    (reg_wdata[BYTE_W-1]),
    .len    (xfer_len_f(n_cnt_lo, n_cnt_mid)),
    .pulse  (seq_start),
    .code_q (seq_code),
    .dma_q  (seq_dma),
    .len_q  (seq_len)
  );

  // R3
  intr_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_intr_rd && !reg_wr) |=> (!irq && intr_q == '0 && step_q == STEP_ACK));
  // R4
  count_write_drops_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_CNT_LO || reg_addr == RA_CNT_MID)) |=> !stat_q[ST_TC_BIT]);
  // R8
  busrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_wr && reg_wdata[CODE_W-1:0] == OP_BUSRST && cfg1_q[CFG1_QUIET_BIT] &&
     !seq_done && !reg_rd) |=> (irq == $past(irq)));
  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_wr && reg_wdata[CODE_W-1:0] == OP_RESET) |=> (cfg1_q == CFG1_RESET && !irq));
  // R11
  start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> $past(reg_wr && reg_addr == RA_CMD));
  // R13
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_wr && !is_known_f(reg_wdata[CODE_W-1:0]) && !seq_done && !reg_rd)
      |=> ($stable(stat_q) && $stable(intr_q) && $stable(step_q) && $stable(flags_q)));
endmodule

// File: tb/scsi_cmd_regs_bench.sv
module scsi_cmd_regs_bench;
  localparam logic [7:0] CHIP = 8'h04;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, seq_done = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, done_status = '0, done_intr = '0, done_step = '0, done_flags = '0;
  logic [7:0] reg_rdata;
  logic irq, seq_start, seq_dma;
  logic [6:0] seq_code;
  logic [16:0] seq_len;

  always #10 clk = ~clk;

  scsi_cmd_regs #(.CHIP_ID(CHIP)) u_scsi_cmd_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .seq_start(seq_start),
    .seq_code(seq_code), .seq_dma(seq_dma), .seq_len(seq_len), .seq_done(seq_done),
    .done_status(done_status), .done_intr(done_intr), .done_step(done_step),
    .done_flags(done_flags)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] m [16];
  logic [7:0] sh_lo, sh_mid;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // bench-side model
  task automatic m_reset();
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    m[8] = 8'h07; m[14] = CHIP; sh_lo = 0; sh_mid = 0;
  endtask

  task automatic m_write(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'h0: begin sh_lo = d; m[4][4] = 1'b0; end
      4'h1: begin sh_mid = d; m[4][4] = 1'b0; end
      4'h3: begin
        m[3] = d;
        if (d[7]) begin m[0] = sh_lo; m[1] = sh_mid; end
        case (d[6:0])
          7'h01: begin m[5] = 8'h08; m[6] = 0; m[7] = 0; end
          7'h02: m_reset();
          7'h03: begin m[5] = 8'h80; if (!m[8][6]) m[4][7] = 1'b1; end
          7'h12: begin m[5] = 8'h20; m[6] = 0; m[7] = 0; m[4][7] = 1'b1; end
          7'h18: begin m[4] = 8'h10; m[5] = 8'h08; m[6] = 0; end
          7'h44: m[5] = 0;
          7'h45: begin m[5] = 0; m[4][7] = 1'b1; end
          default: ;
        endcase
      end
      4'h8, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF: m[a] = d;
      default: ;
    endcase
  endtask

  task automatic m_rdintr();
    m[5] = 0; m[4][4] = 1'b0; m[4][7] = 1'b0; m[6] = 8'h04;
  endtask

  task automatic m_done(input logic [7:0] s, i, q, f);
    m[4] = s | 8'h80; m[5] = i; m[6] = q; m[7] = f;
  endtask

  function automatic logic [16:0] exp_len(input logic [7:0] lo, mid);
    return ({mid, lo} == 16'h0) ? 17'h10000 : {1'b0, mid, lo};
  endfunction

  // port drivers
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic check_reg(input string tag, input logic [3:0] a);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, m[a]);
    if (a == 4'h5) m_rdintr();
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 16; a++) if (a != 5) check_reg(tag, 4'(a));
    chk(tag, irq, m[4][7]);
  endtask

  task automatic done_pulse(input logic [7:0] s, i, q, f);
    @(negedge clk); seq_done = 1'b1; done_status = s; done_intr = i; done_step = q; done_flags = f;
    @(negedge clk); seq_done = 1'b0;
    m_done(s, i, q, f);
  endtask

  initial begin
    #(20 * 150000);
    chk("R2 watchdog expired", 1, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [31:0] r;
    r = $urandom(32'h5c5105);
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    sweep("R1 reset");
    check_reg("R1 intr reset", 4'h5);

    // R4 shadow writes, no readback change
    wr(4'h0, 8'h34); wr(4'h1, 8'h12);
    check_reg("R4 lo unchanged", 4'h0);
    check_reg("R4 mid unchanged", 4'h1);
    // R7 pad
    wr(4'h3, 8'h18);
    check_reg("R7 pad status", 4'h4);
    check_reg("R7 pad step", 4'h6);
    // R4 write clears terminal count
    wr(4'h0, 8'h34);
    check_reg("R4 tc cleared", 4'h4);

    // R5 / R11 DMA transfer command
    @(negedge clk); reg_addr = 4'h3; reg_wdata = 8'h90; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; m_write(4'h3, 8'h90);
    chk("R11 start high", seq_start, 1);
    chk("R11 code", seq_code, 7'h10);
    chk("R11 dma", seq_dma, 1);
    chk("R11 len", seq_len, exp_len(8'h34, 8'h12));
    @(negedge clk);
    chk("R11 start one cycle", seq_start, 0);
    check_reg("R5 lo reload", 4'h0);
    check_reg("R5 mid reload", 4'h1);
    check_reg("R5 cmd readback", 4'h3);

    // R11 zero count means 65536
    wr(4'h0, 8'h00); wr(4'h1, 8'h00);
    @(negedge clk); reg_addr = 4'h3; reg_wdata = 8'hC2; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; m_write(4'h3, 8'hC2);
    chk("R11 select code", seq_code, 7'h42);
    chk("R11 zero len", seq_len, 17'h10000);
    // R11 non-DMA select uses current readable count
    wr(4'h0, 8'h05);
    @(negedge clk); reg_addr = 4'h3; reg_wdata = 8'h41; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; m_write(4'h3, 8'h41);
    chk("R11 nodma start", seq_start, 1);
    chk("R11 nodma flag", seq_dma, 0);
    chk("R11 nodma len", seq_len, 17'h10000);

    // R12 done, then R3 destructive read
    done_pulse(8'h11, 8'h18, 8'h02, 8'h03);
    chk("R12 irq on done", irq, 1);
    check_reg("R12 status", 4'h4);
    check_reg("R12 flags", 4'h7);
    check_reg("R3 old intr value", 4'h5);
    chk("R3 irq lowered", irq, 0);
    check_reg("R3 status tc cleared", 4'h4);
    check_reg("R3 step", 4'h6);
    check_reg("R3 intr zero", 4'h5);

    // R6 flush keeps status
    done_pulse(8'h02, 8'h00, 8'h03, 8'h05);
    wr(4'h3, 8'h01);
    sweep("R6 flush");
    check_reg("R6 intr", 4'h5);

    // R8 bus reset, quiet then loud
    wr(4'h8, 8'h47);
    wr(4'h3, 8'h03);
    chk("R8 quiet irq", irq, 0);
    check_reg("R8 quiet intr", 4'h5);
    wr(4'h8, 8'h07);
    wr(4'h3, 8'h03);
    chk("R8 raise irq", irq, 1);
    check_reg("R8 intr", 4'h5);

    // R9 message accept, enable/disable selection
    wr(4'h3, 8'h12);
    chk("R9 msgok irq", irq, 1);
    sweep("R9 msgok");
    check_reg("R9 msgok intr", 4'h5);
    wr(4'h3, 8'h45);
    chk("R9 dissel irq", irq, 1);
    check_reg("R9 dissel intr", 4'h5);
    wr(4'h3, 8'h12);
    wr(4'h3, 8'h44);
    chk("R9 ensel keeps irq", irq, 1);
    check_reg("R9 ensel intr", 4'h5);

    // R13 unknown code
    done_pulse(8'h05, 8'h18, 8'h02, 8'h09);
    wr(4'h3, 8'h7E);
    sweep("R13 unknown");

    // R12 precedence: done and intr read in the same cycle
    @(negedge clk); seq_done = 1'b1; done_status = 8'h13; done_intr = 8'h0C;
    done_step = 8'h01; done_flags = 8'h06; reg_addr = 4'h5; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk); seq_done = 1'b0; reg_rd = 1'b0;
    chk("R12 same-cycle read value", v, m[5]);
    m_done(8'h13, 8'h0C, 8'h01, 8'h06); m_rdintr();
    sweep("R12 same-cycle");

    // R14 config and ignored writes
    for (int a = 2; a < 16; a++) if (a != 3) wr(4'(a), 8'hA0 + 8'(a));
    sweep("R14 writes");

    // R10 reset command
    wr(4'h3, 8'h82);
    sweep("R10 soft reset");
    check_reg("R10 intr", 4'h5);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [3:0] a;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      if (op < 4) begin
        if (a == 4'h3) begin
          case ($urandom_range(0, 9))
            0: d[6:0] = 7'h01; 1: d[6:0] = 7'h03; 2: d[6:0] = 7'h12; 3: d[6:0] = 7'h18;
            4: d[6:0] = 7'h44; 5: d[6:0] = 7'h45; 6: d[6:0] = 7'h10; 7: d[6:0] = 7'h43;
            8: d[6:0] = (n % 5 == 0) ? 7'h02 : 7'h00;
            default: ;
          endcase
        end
        wr(a, d);
      end else if (op < 8) begin
        check_reg("R13 random read", a);
      end else begin
        done_pulse(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      end
      chk("R2 random irq", irq, m[4][7]);
    end
    sweep("R14 final sweep");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule